// File: doc/BRIEF.md
# PWM Timer Channel with Middle Reference

This block is one channel of a general-purpose timer. A free-running up-counter advances once for each cycle in which the selected count-enable tick is high. The count is compared against two values: a terminal reference, which closes the period, and a middle reference, which shapes the duty cycle. When the count arrives at the terminal reference, the waveform output goes high and a one-cycle reference-reached pulse is issued. The counter then wraps to zero on the next tick. When PWM operation is enabled and the count arrives at the middle reference, the waveform output is cleared. The clear is deferred to the falling edge of the one-cycle tick pulse, which is one clock after the compare edge.

Software changes the duty cycle by moving the middle reference anywhere from 0 to the terminal reference minus 1. The reference-reached pulse is also presented gated by an interrupt enable, so that interrupt logic elsewhere can latch it. All inputs are plain control pins; no data stream passes through the block, so there is no valid/ready handshake. Clock prescaling, register decode and interrupt aggregation are handled outside this block.

Top module: `pwm_mref_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count to 0 and drives `wave_o`, `hit_o` and `irq_o` to 0 after that edge.
- R2: The count changes only at clock edges where `tick_i` is 1. At those edges it moves by one step. At all other edges it holds.
- R3: At the edge where a tick moves the count onto `term_ref_i`, `wave_o` becomes 1 and `hit_o` is 1 for the following cycle only, unless the next edge produces another match.
- R4: A tick taken while the count equals `term_ref_i` moves the count to 0, and counting continues from there.
- R5: With `pwm_en_i` = 1 at the edge where a tick moves the count onto `mid_ref_i`, `wave_o` falls to 0 one clock later. With a tick every P ≥ 2 cycles, `wave_o` is therefore high for (mid+1)·P + 1 of every (term+1)·P cycles.
- R6: With `pwm_en_i` = 0 at that edge, the middle-reference match leaves `wave_o` unchanged.
- R7: If a deferred clear and a terminal match fall on the same edge, the set wins and `wave_o` stays 1. With a tick every cycle and mid = term−1, the output therefore stays high.
- R8: `irq_o` equals the value `hit_o` takes at the same edge, ANDed with `irq_en_i` sampled at that edge.
- R9: The count and reference width `CNT_W` is 16 by default and may be set to 20. The full range is usable: with term = 2^CNT_W−1, a match occurs after 2^CNT_W−1 ticks from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count-enable tick from the selected clock source |
| term_ref_i | input | CNT_W | Terminal reference; a match sets the output and ends the period |
| mid_ref_i | input | CNT_W | Middle reference; a match clears the output when PWM is enabled |
| pwm_en_i | input | 1 | Enables the middle-reference clear |
| irq_en_i | input | 1 | Gates the reference-reached pulse onto `irq_o` |
| wave_o | output | 1 | PWM waveform output |
| hit_o | output | 1 | One-cycle pulse when the count reaches the terminal reference |
| irq_o | output | 1 | `hit_o` gated by the interrupt enable |

## Verification
The results arrive at two fixed latencies. The terminal set, `hit_o` and `irq_o` all appear right after the clock edge that takes the tick. The middle-reference clear appears one edge after that. The bench drives inputs on falling clock edges and updates a behavioural model on rising edges. It compares all three outputs on every falling edge, so each result is checked in the exact cycle the requirements assign to it. Duty checks count the high samples over one whole period, which does not depend on where the window starts. They cover tick spacing of 1 and 3 cycles, PWM enabled and disabled, and mid = 0 and mid = term−1.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  // Action applied to the waveform register at a clock edge.
  typedef enum logic [1:0] {
    WAVE_HOLD = 2'd0,
    WAVE_SET  = 2'd1,
    WAVE_CLR  = 2'd2
  } wave_op_e;

  function automatic bit width_supported(input int w);
    return (w == 16) || (w == 20);
  endfunction
endpackage

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] term_ref_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  // Value the counter takes at the edge that accepts a tick.
  always_comb begin
    if (count_q == term_ref_i) next_o = '0;
    else                       next_o = count_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (tick_i) count_q <= next_o;
  end

  assign step_o  = tick_i;
  assign count_o = count_q;
endmodule

// File: rtl/pwm_tmr_cmp.sv
module pwm_tmr_cmp
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] term_ref_i,
  input  logic [CNT_W-1:0] mid_ref_i,
  input  logic             pwm_en_i,
  output logic             term_hit_o,
  output wave_op_e         op_o
);
  logic mid_hit;
  logic clr_pend_q;

  assign term_hit_o = step_i && (next_i == term_ref_i);
  assign mid_hit    = step_i && pwm_en_i && (next_i == mid_ref_i);

  // The clear waits for the falling edge of the one-cycle tick pulse.
  always_ff @(posedge clk) begin
    if (rst) clr_pend_q <= 1'b0;
    else     clr_pend_q <= mid_hit;
  end

  always_comb begin
    if (term_hit_o)      op_o = WAVE_SET;
    else if (clr_pend_q) op_o = WAVE_CLR;
    else                 op_o = WAVE_HOLD;
  end
endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wave_op_e op_i,
  input  logic     term_hit_i,
  input  logic     irq_en_i,
  output logic     wave_o,
  output logic     hit_o,
  output logic     irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_o <= 1'b0;
      hit_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      unique case (op_i)
        WAVE_SET: wave_o <= 1'b1;
        WAVE_CLR: wave_o <= 1'b0;
        default:  wave_o <= wave_o;
      endcase
      hit_o <= term_hit_i;
      irq_o <= term_hit_i && irq_en_i;
    end
  end
endmodule

// File: rtl/pwm_mref_timer.sv
module pwm_mref_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] term_ref_i,
  input  logic [CNT_W-1:0] mid_ref_i,
  input  logic             pwm_en_i,
  input  logic             irq_en_i,
  output logic             wave_o,
  output logic             hit_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] next_w;
  logic             step_w;
  logic             term_hit_w;
  wave_op_e         op_w;

  pwm_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .term_ref_i (term_ref_i),
    .count_o    (count_q),
    .next_o     (next_w),
    .step_o     (step_w)
  );

  pwm_tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_w),
    .next_i     (next_w),
    .term_ref_i (term_ref_i),
    .mid_ref_i  (mid_ref_i),
    .pwm_en_i   (pwm_en_i),
    .term_hit_o (term_hit_w),
    .op_o       (op_w)
  );

  pwm_tmr_wave u_wave (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_w),
    .term_hit_i (term_hit_w),
    .irq_en_i   (irq_en_i),
    .wave_o     (wave_o),
    .hit_o      (hit_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/pwm_mref_timer_chk.sv
module pwm_mref_timer_chk
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic [CNT_W-1:0] term_ref_i,
  input logic             pwm_en_i,
  input logic             irq_en_i,
  input logic [CNT_W-1:0] count_q,
  input logic             wave_o,
  input logic             hit_o,
  input logic             irq_o
);
  initial begin
    p_width_r9: assert (width_supported(CNT_W));
  end

  // R1: reset state seen on the cycle after a reset edge
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (count_q == '0) && !wave_o && !hit_o && !irq_o);

  // R2: no tick, no count change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_i)) |-> $stable(count_q));

  // R2: a terminal pulse needs a tick at the previous edge
  p_hit_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !$past(rst)) |-> $past(tick_i));

  // R3: a terminal pulse always comes with the output high
  p_hit_sets_wave_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> wave_o);

  // R4: wrap to zero after the terminal count
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick_i) && ($past(count_q) == $past(term_ref_i)))
      |-> (count_q == '0));

  // R6: a falling output needs PWM enabled and a tick two edges back
  p_no_clear_without_pwm_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(wave_o) && !$past(rst) && !$past(rst, 2))
      |-> ($past(pwm_en_i, 2) && $past(tick_i, 2)));

  // R8: interrupt pulse is the gated terminal pulse
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == (hit_o && $past(irq_en_i))));
endmodule

bind pwm_mref_timer pwm_mref_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .term_ref_i (term_ref_i),
  .pwm_en_i   (pwm_en_i),
  .irq_en_i   (irq_en_i),
  .count_q    (count_q),
  .wave_o     (wave_o),
  .hit_o      (hit_o),
  .irq_o      (irq_o)
);

// File: tb/pwm_mref_timer_test.sv
`timescale 1ns/1ps
module pwm_mref_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_i = 1'b0;
  logic [W-1:0] term_ref_i = '0;
  logic [W-1:0] mid_ref_i = '0;
  logic         pwm_en_i = 1'b0;
  logic         irq_en_i = 1'b0;
  logic         wave_o, hit_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  pwm_mref_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .term_ref_i(term_ref_i),
    .mid_ref_i(mid_ref_i), .pwm_en_i(pwm_en_i), .irq_en_i(irq_en_i),
    .wave_o(wave_o), .hit_o(hit_o), .irq_o(irq_o)
  );

  // Behavioural reference model, advanced on every rising edge.
  int m_cnt = 0;
  bit m_pend = 0, m_wave = 0, m_hit = 0, m_irq = 0;
  always @(posedge clk) begin
    int nxt;
    bit th;
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_wave = 0; m_hit = 0; m_irq = 0;
    end else begin
      nxt = m_cnt;
      if (tick_i) nxt = (m_cnt == int'(term_ref_i)) ? 0 : (m_cnt + 1) % (1 << W);
      th = tick_i && (nxt == int'(term_ref_i));
      if (th) m_wave = 1;
      else if (m_pend) m_wave = 0;
      m_hit  = th;
      m_irq  = th && irq_en_i;
      m_pend = tick_i && pwm_en_i && (nxt == int'(mid_ref_i));
      m_cnt  = nxt;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model; tick spaced every 'period' cycles.
  int phase = 0;
  int high_cnt = 0;
  task automatic run(input int cycles, input int period, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check({req, " wave"}, int'(wave_o), int'(m_wave));
      check({req, " hit"},  int'(hit_o),  int'(m_hit));
      check({req, " irq"},  int'(irq_o),  int'(m_irq));
      if (wave_o) high_cnt++;
      tick_i = (phase == 0);
      phase  = (phase + 1) % period;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_i = 1'b0; phase = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset wave", int'(wave_o), 0);
    check("R1 reset hit",  int'(hit_o),  0);
    check("R1 reset irq",  int'(irq_o),  0);
  endtask

  initial begin
    int steps;
    do_reset();

    // R2/R3/R4/R5: tick every 3 cycles, term 9, mid 4, PWM on, irq on
    term_ref_i = 16'd9; mid_ref_i = 16'd4; pwm_en_i = 1; irq_en_i = 1;
    run(90, 3, "R5");
    high_cnt = 0;
    run(30, 3, "R5");
    check("R5 duty high cycles (tick/3)", high_cnt, 16);

    // R2: ticks stop, outputs and count hold
    tick_i = 0;
    repeat (7) begin
      @(negedge clk);
      check("R2 hold hit", int'(hit_o), 0);
      check("R2 hold wave", int'(wave_o), int'(m_wave));
    end

    // R6: PWM disabled, output stays high once set
    do_reset();
    pwm_en_i = 0;
    run(60, 3, "R6");
    high_cnt = 0;
    run(30, 3, "R6");
    check("R6 wave never cleared", high_cnt, 30);

    // R8: interrupt gated off while hits continue
    irq_en_i = 0;
    run(40, 1, "R8");

    // R5 with tick every cycle, mid 0: high mid+2 of term+1 cycles
    do_reset();
    pwm_en_i = 1; irq_en_i = 1; mid_ref_i = 16'd0;
    run(40, 1, "R4");
    high_cnt = 0;
    run(10, 1, "R5");
    check("R5 duty mid=0", high_cnt, 2);

    // R7: mid = term-1, tick every cycle, set wins over deferred clear
    mid_ref_i = 16'd8;
    run(30, 1, "R7");
    high_cnt = 0;
    run(20, 1, "R7");
    check("R7 set priority keeps output high", high_cnt, 20);

    // R1: reset in mid-run
    do_reset();

    // R9: full-width terminal reference
    term_ref_i = 16'hFFFF; mid_ref_i = 16'd100; pwm_en_i = 0;
    steps = 0;
    @(negedge clk);
    tick_i = 1;
    while (!hit_o && steps < 70000) begin
      @(negedge clk);
      steps++;
    end
    check("R9 ticks to reach full-range term", steps, 65535);
    check("R9 wave at full-range term", int'(wave_o), 1);
    run(20, 1, "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule